// File: doc/BRIEF.md
# Incremental Encoder Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder into a position count. Both phase inputs are first brought into the local clock domain. Each edge of a phase input that the selected counting mode accepts then moves the count by one step, up or down. The step direction comes from the phase relationship between the two signals, and the block reports the direction of the most recent counted step.

The count runs between zero and a software-supplied auto-reload value and wraps at both ends. Software can load any value into the count to set a known position. A three-bit counting-mode code chooses among three options: count edges of phase A only, count edges of phase B only, or count edges of both phases. The last option gives four counts per encoder cycle, so each count is a quarter of a cycle.

Top module: `qenc_counter`

## Requirements
- R1: After reset, `count_o` is 0 and `dir_o` is 0.
- R2: With mode code 3, every single-phase edge on either input is counted. A full encoder cycle in which A leads B (A,B = 00, 10, 11, 01, 00) adds 4 to the count.
- R3: With mode code 1, only edges of phase A are counted. Edges of phase B leave the count and `dir_o` unchanged, so a full cycle moves the count by 2.
- R4: With mode code 2, only edges of phase B are counted. Edges of phase A leave the count and `dir_o` unchanged.
- R5: The direction of a counted edge is set by the level of the other phase. An A edge counts up when A differs from B after the edge. A B edge counts up when A equals B after the edge. `dir_o` holds 0 after an up step and 1 after a down step, and it keeps its value until the next counted edge.
- R6: An up step taken when the count is at or above the auto-reload value sets the count to 0.
- R7: A down step taken at count 0 sets the count to the auto-reload value.
- R8: A one-cycle pulse on `cnt_wr_i` loads `cnt_wr_data_i` into the count on the next clock edge. When a write and a counted edge fall in the same cycle, the written value is kept and the step is lost. `dir_o` still takes that step's direction.
- R9: If both phases change between two synchronised samples, no step is taken. The count and `dir_o` keep their values. Later edges are judged against the new levels.
- R10: Mode codes 0 and 4 to 7 count nothing and leave `dir_o` unchanged. The phase levels are still tracked, so a later switch to a counting mode does not produce a false step.
- R11: A phase change shows on `count_o` at the third rising clock edge after it is applied: two synchroniser stages, then the count register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_a_i | input | 1 | Encoder phase A, asynchronous |
| enc_b_i | input | 1 | Encoder phase B, asynchronous |
| slave_mode_i | input | 3 | Counting mode: 1 = A edges, 2 = B edges, 3 = both; other codes count nothing |
| reload_i | input | CNT_W | Auto-reload value, the top of the counting range |
| cnt_wr_i | input | 1 | Write strobe for the count |
| cnt_wr_data_i | input | CNT_W | Value loaded by the write strobe |
| count_o | output | CNT_W | Current position count |
| dir_o | output | 1 | Direction of the last counted step: 0 up, 1 down |

## Verification
A software write of the count and a counted encoder edge can arrive in the same cycle. The bench provokes this by raising a phase input and placing the write strobe exactly on the third rising edge after that change, which is the edge where the step would otherwise land. The expected outcome is the written value, with the direction flag taking the lost step's direction. The bench then waits several cycles to confirm that the dropped step does not appear later.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
   localparam int MODE_W = 3;
   localparam logic [MODE_W-1:0] SM_PHASE_A = 3'd1;
   localparam logic [MODE_W-1:0] SM_PHASE_B = 3'd2;
   localparam logic [MODE_W-1:0] SM_BOTH    = 3'd3;

   function automatic logic mode_takes_a(input logic [MODE_W-1:0] m);
      return (m == SM_PHASE_A) || (m == SM_BOTH);
   endfunction

   function automatic logic mode_takes_b(input logic [MODE_W-1:0] m);
      return (m == SM_PHASE_B) || (m == SM_BOTH);
   endfunction
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qenc_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("qenc_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder
   import qenc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_i,
   input  logic              b_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic              step_o,
   output logic              down_o,
   output logic              dir_o
);
   logic a_prev, b_prev, dir_q;
   logic a_edge, b_edge, lone_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_prev <= 1'b0;
         b_prev <= 1'b0;
      end else begin
         a_prev <= a_i;
         b_prev <= b_i;
      end
   end

   assign a_edge    = a_i ^ a_prev;
   assign b_edge    = b_i ^ b_prev;
   assign lone_edge = a_edge ^ b_edge;

   always_comb begin
      step_o = lone_edge & ((a_edge & mode_takes_a(mode_i)) |
                            (b_edge & mode_takes_b(mode_i)));
      down_o = a_edge ? (a_i == b_i) : (a_i != b_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= 1'b0;
      else if (step_o) dir_q <= down_o;
   end

   assign dir_o = dir_q;

   p_both_move_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (a_edge && b_edge) |-> !step_o);
   p_idle_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd0 || mode_i > SM_BOTH) |-> !step_o);
   p_dir_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !step_o |=> $stable(dir_o));
   p_a_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == SM_PHASE_A && b_edge) |-> !step_o);
endmodule

// File: rtl/qenc_wrapcnt.sv
module qenc_wrapcnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             down_i,
   input  logic [CNT_W-1:0] reload_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] count_o
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("qenc_wrapcnt: CNT_W must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (step_i) begin
         if (down_i) cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - ONE;
         else        cnt_q <= (cnt_q >= reload_i) ? '0 : cnt_q + ONE;
      end
   end

   assign count_o = cnt_q;

   p_wrap_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !down_i && !load_i && cnt_q == reload_i) |=> (cnt_q == '0));
   p_wrap_bottom_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && down_i && !load_i && cnt_q == '0) |=> (cnt_q == $past(reload_i)));
   p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(load_val_i)));
   p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
   import qenc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enc_a_i,
   input  logic              enc_b_i,
   input  logic [MODE_W-1:0] slave_mode_i,
   input  logic [CNT_W-1:0]  reload_i,
   input  logic              cnt_wr_i,
   input  logic [CNT_W-1:0]  cnt_wr_data_i,
   output logic [CNT_W-1:0]  count_o,
   output logic              dir_o
);
   logic [1:0] phase_s;
   logic       step, down;

   qenc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({enc_b_i, enc_a_i}),
      .q_o   (phase_s)
   );

   qenc_decoder u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_i    (phase_s[0]),
      .b_i    (phase_s[1]),
      .mode_i (slave_mode_i),
      .step_o (step),
      .down_o (down),
      .dir_o  (dir_o)
   );

   qenc_wrapcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (step),
      .down_i     (down),
      .reload_i   (reload_i),
      .load_i     (cnt_wr_i),
      .load_val_i (cnt_wr_data_i),
      .count_o    (count_o)
   );

   p_dir_tracks_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cnt_wr_i) |=> (dir_o == $past(down)));
endmodule

// File: tb/sim_qenc_counter.sv
module sim_qenc_counter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a = 1'b0, b = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic [15:0] reload = 16'd9;
   logic        wr = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] count;
   logic        dir;
   int          n_chk = 0, n_bad = 0;
   bit          done = 0;

   always #10 clk = ~clk;

   qenc_counter #(.CNT_W(16), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .enc_a_i(a), .enc_b_i(b),
      .slave_mode_i(mode), .reload_i(reload), .cnt_wr_i(wr),
      .cnt_wr_data_i(wr_data), .count_o(count), .dir_o(dir));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pins(input logic na, input logic nb);
      @(negedge clk); a = na; b = nb;
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load(input logic [15:0] v);
      @(negedge clk); wr = 1'b1; wr_data = v;
      @(posedge clk);
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 count", count, 16'd0);
      chk("R1 dir", {15'd0, dir}, 16'd0);
   endtask

   task automatic t_quad;
      mode = 3'd3;
      pins(1, 0); pins(1, 1); pins(0, 1);
      chk("R2 three quarters", count, 16'd3);
      pins(0, 0);
      chk("R2 full cycle up", count, 16'd4);
      chk("R5 dir up", {15'd0, dir}, 16'd0);
      pins(0, 1); pins(1, 1); pins(1, 0); pins(0, 0);
      chk("R5 full cycle down", count, 16'd0);
      chk("R5 dir down", {15'd0, dir}, 16'd1);
   endtask

   task automatic t_latency;
      load(16'd5);
      chk("R8 load", count, 16'd5);
      @(negedge clk); a = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R11 not yet", count, 16'd5);
      @(posedge clk); @(negedge clk);
      chk("R11 third edge", count, 16'd6);
      pins(0, 0);
      chk("R5 A falls B low down", count, 16'd5);
   endtask

   task automatic t_phase_a;
      mode = 3'd1;
      pins(1, 0);
      chk("R3 A edge", count, 16'd6);
      pins(1, 1);
      chk("R3 B edge ignored", count, 16'd6);
      chk("R3 dir", {15'd0, dir}, 16'd0);
      pins(0, 1); pins(0, 0);
      chk("R3 full cycle", count, 16'd7);
   endtask

   task automatic t_phase_b;
      mode = 3'd2;
      pins(0, 1);
      chk("R4 B edge down", count, 16'd6);
      chk("R4 dir", {15'd0, dir}, 16'd1);
      pins(1, 1);
      chk("R4 A edge ignored", count, 16'd6);
      pins(1, 0); pins(0, 0);
      chk("R4 full cycle", count, 16'd5);
   endtask

   task automatic t_wrap;
      mode = 3'd3;
      load(16'd8);
      pins(1, 0);
      chk("R6 reach top", count, 16'd9);
      pins(1, 1);
      chk("R6 wrap to zero", count, 16'd0);
      pins(0, 1); pins(0, 0);
      load(16'd1);
      pins(0, 1);
      chk("R7 reach zero", count, 16'd0);
      pins(1, 1);
      chk("R7 wrap to reload", count, 16'd9);
      pins(1, 0); pins(0, 0);
      chk("R7 continue down", count, 16'd7);
   endtask

   task automatic t_double;
      pins(1, 1);
      chk("R9 count held", count, 16'd7);
      chk("R9 dir held", {15'd0, dir}, 16'd1);
      pins(0, 1);
      chk("R9 next edge from new level", count, 16'd8);
      chk("R9 dir up", {15'd0, dir}, 16'd0);
      pins(0, 0);
   endtask

   task automatic t_idle_mode;
      mode = 3'd0;
      pins(0, 1);
      chk("R10 code0 count", count, 16'd9);
      mode = 3'd6;
      pins(1, 1);
      chk("R10 code6 count", count, 16'd9);
      chk("R10 dir held", {15'd0, dir}, 16'd0);
      mode = 3'd3;
      pins(1, 0);
      chk("R10 resume no false step", count, 16'd8);
      pins(0, 0);
      chk("R10 resume down", count, 16'd7);
   endtask

   task automatic t_collide;
      @(negedge clk); a = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk); wr = 1'b1; wr_data = 16'd3;
      @(posedge clk);
      @(negedge clk); wr = 1'b0;
      chk("R8 write wins", count, 16'd3);
      chk("R8 dir from lost step", {15'd0, dir}, 16'd0);
      repeat (4) @(negedge clk);
      chk("R8 step not replayed", count, 16'd3);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_quad();
      t_latency();
      t_phase_a();
      t_phase_b();
      t_wrap();
      t_double();
      t_idle_mode();
      t_collide();
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule